// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms a 64-bit memory effective address from up to three terms: a base register value, an index register value shifted left by a 2-bit scale amount, and a sign-extended constant displacement. Each term may be absent. The base and index values come from a 16-entry, 64-bit integer register file inside the block. The register file has two read ports, one for the base and one for the index, and one write port used to load register values.

A request carries these fields:
- base and index register numbers, each with a present flag;
- a scale code;
- a displacement with a width code;
- an operand-size code.

The block registers the sum and presents it one clock later with a valid strobe. The access size in bytes, decoded from the operand-size code, is output alongside the address. Register number 4 is reserved as the stack pointer and never acts as an index.

Top module: `ea_scaled_agen`

## Requirements
- R1: The address is base + (index << scale) + sign-extended displacement, taken modulo 2^64.
- R2: The address appears on `ea_addr` one cycle after `req_valid` is sampled high. `ea_valid` is high in exactly the cycle after a sampled request and low otherwise. After a synchronous reset, `ea_valid`, `ea_addr` and `ea_bytes` are all zero.
- R3: `req_scale` values 0, 1, 2 and 3 multiply the index value by 1, 2, 4 and 8.
- R4: `req_disp_w` selects how much of `req_disp` is used:
  - 0: no displacement;
  - 1: bits 7:0;
  - 2: bits 15:0;
  - 3: bits 31:0.

  The selected field is sign-extended to 64 bits. The bits of `req_disp` above the selected field have no effect.
- R5: When `req_base_on` is 0, the base contributes zero, whatever `req_base_sel` holds.
- R6: The index contributes zero when `req_idx_on` is 0 or when `req_idx_sel` equals 4.
- R7: `req_size` values 0, 1, 2 and 3 give `ea_bytes` values of 1, 2, 4 and 8. The byte count is registered together with the address.
- R8: A write through `wr_en`, `wr_sel` and `wr_data` takes effect at the clock edge. A request that reads the same register in the same cycle sees the old value.
- R9: Cycles without a request leave `ea_addr` and `ea_bytes` unchanged.
- R10: A sum that exceeds 64 bits wraps to its low 64 bits. This includes a negative displacement added to a small base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register file write enable |
| wr_sel | input | 4 | Register number to write |
| wr_data | input | 64 | Value to write |
| req_valid | input | 1 | Request present this cycle |
| req_base_on | input | 1 | Base term present |
| req_base_sel | input | 4 | Base register number |
| req_idx_on | input | 1 | Index term present |
| req_idx_sel | input | 4 | Index register number (4 means no index) |
| req_scale | input | 2 | Index shift amount, 0 to 3 |
| req_disp_w | input | 2 | Displacement width code |
| req_disp | input | 32 | Displacement field |
| req_size | input | 2 | Operand-size code |
| ea_valid | output | 1 | Result strobe |
| ea_addr | output | 64 | Effective address |
| ea_bytes | output | 4 | Access size in bytes |

## Verification
The case that is hardest to reach from the ports is a request that reads a register during the same cycle in which that register is being written. The stimulus schedules a write and a matching base-and-index read in one cycle, so the result must be built from the old value. A second request then shows the new value.

Wrap-around is reached by loading a register with a value close to 2^64 and adding a positive displacement. It is also reached by adding a negative 8-bit displacement to a small base. Further requests fill the upper bits of `req_disp` with random data to show that those bits have no effect.

// File: rtl/ea_pkg.sv
package ea_pkg;
   localparam int ADDR_W   = 64;
   localparam int NUM_REGS = 16;
   localparam int SEL_W    = $clog2(NUM_REGS);
   localparam int DISP_W   = 32;
   localparam int SP_NUM   = 4;

   typedef enum logic [1:0] {
      DW_NONE = 2'd0,
      DW_8    = 2'd1,
      DW_16   = 2'd2,
      DW_32   = 2'd3
   } disp_w_e;
endpackage

// File: rtl/ea_regfile.sv
module ea_regfile #(
   parameter int W        = 64,
   parameter int N        = 16,
   parameter bit RF_RESET = 1'b1,
   localparam int SW      = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic [SW-1:0] wr_sel,
   input  logic [W-1:0]  wr_data,
   input  logic [SW-1:0] rd_a_sel,
   output logic [W-1:0]  rd_a_val,
   input  logic [SW-1:0] rd_b_sel,
   output logic [W-1:0]  rd_b_val
);
   logic [W-1:0] q [N];

   if (N < 2 || (1 << SW) != N) begin : g_bad_n
      $error("ea_regfile: N must be a power of two of at least 2");
   end

   for (genvar g = 0; g < N; g++) begin : g_ent
      if (RF_RESET) begin : g_rst
         always_ff @(posedge clk) begin
            if (rst)
               q[g] <= '0;
            else if (wr_en && wr_sel == SW'(g))
               q[g] <= wr_data;
         end
      end else begin : g_nrst
         always_ff @(posedge clk) begin
            if (wr_en && wr_sel == SW'(g))
               q[g] <= wr_data;
         end
      end
   end

   assign rd_a_val = q[rd_a_sel];
   assign rd_b_val = q[rd_b_sel];

   // R8
   wr_lands_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !rst) |=> (q[$past(wr_sel)] == $past(wr_data)));
endmodule

// File: rtl/ea_disp_ext.sv
module ea_disp_ext #(
   parameter int AW = 64,
   parameter int DW = 32
) (
   input  logic [1:0]    code,
   input  logic [DW-1:0] raw,
   output logic [AW-1:0] ext
);
   import ea_pkg::*;

   if (DW != 32 || AW < DW) begin : g_bad_w
      $error("ea_disp_ext: DW must be 32 and AW must be at least DW");
   end

   always_comb begin
      unique case (disp_w_e'(code))
         DW_8:    ext = {{(AW-8){raw[7]}},   raw[7:0]};
         DW_16:   ext = {{(AW-16){raw[15]}}, raw[15:0]};
         DW_32:   ext = {{(AW-32){raw[31]}}, raw[31:0]};
         default: ext = '0;
      endcase
   end

   // R4
   disp_sign_chk: assert final ((code == 2'd0) ? (ext == '0) : (ext[AW-1] == ext[AW-2]));
endmodule

// File: rtl/ea_sum.sv
module ea_sum #(
   parameter int AW     = 64,
   parameter int SW     = 4,
   parameter int SP_NUM = 4
) (
   input  logic          base_on,
   input  logic [AW-1:0] base_val,
   input  logic          idx_on,
   input  logic [SW-1:0] idx_sel,
   input  logic [AW-1:0] idx_val,
   input  logic [1:0]    scale,
   input  logic [AW-1:0] disp,
   output logic [AW-1:0] ea
);
   logic          idx_live;
   logic [AW-1:0] base_term, idx_term;

   if (SP_NUM >= (1 << SW)) begin : g_bad_sp
      $error("ea_sum: SP_NUM outside register range");
   end

   assign idx_live  = idx_on && (idx_sel != SW'(SP_NUM));
   assign base_term = base_on  ? base_val : '0;
   assign idx_term  = idx_live ? (idx_val << scale) : '0;
   assign ea        = base_term + idx_term + disp;
endmodule

// File: rtl/ea_scaled_agen.sv
module ea_scaled_agen (
   input  logic        clk,
   input  logic        rst,
   input  logic        wr_en,
   input  logic [3:0]  wr_sel,
   input  logic [63:0] wr_data,
   input  logic        req_valid,
   input  logic        req_base_on,
   input  logic [3:0]  req_base_sel,
   input  logic        req_idx_on,
   input  logic [3:0]  req_idx_sel,
   input  logic [1:0]  req_scale,
   input  logic [1:0]  req_disp_w,
   input  logic [31:0] req_disp,
   input  logic [1:0]  req_size,
   output logic        ea_valid,
   output logic [63:0] ea_addr,
   output logic [3:0]  ea_bytes
);
   import ea_pkg::*;

   logic [ADDR_W-1:0] base_val, idx_val, disp_ext, ea_next;

   ea_regfile #(.W(ADDR_W), .N(NUM_REGS), .RF_RESET(1'b1)) u_rf (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .rd_a_sel (req_base_sel),
      .rd_a_val (base_val),
      .rd_b_sel (req_idx_sel),
      .rd_b_val (idx_val)
   );

   ea_disp_ext #(.AW(ADDR_W), .DW(DISP_W)) u_disp (
      .code (req_disp_w),
      .raw  (req_disp),
      .ext  (disp_ext)
   );

   ea_sum #(.AW(ADDR_W), .SW(SEL_W), .SP_NUM(SP_NUM)) u_sum (
      .base_on  (req_base_on),
      .base_val (base_val),
      .idx_on   (req_idx_on),
      .idx_sel  (req_idx_sel),
      .idx_val  (idx_val),
      .scale    (req_scale),
      .disp     (disp_ext),
      .ea       (ea_next)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ea_valid <= 1'b0;
         ea_addr  <= '0;
         ea_bytes <= '0;
      end else begin
         ea_valid <= req_valid;
         if (req_valid) begin
            ea_addr  <= ea_next;
            ea_bytes <= 4'(1) << req_size;
         end
      end
   end

   // R2
   valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> ea_valid);
   // R2
   valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> !ea_valid);
   // R9
   addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> ($stable(ea_addr) && $stable(ea_bytes)));
   // R7
   bytes_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      ea_valid |-> ($countones(ea_bytes) == 1));
endmodule

// File: tb/sim_ea_scaled_agen.sv
module sim_ea_scaled_agen;
   logic        clk = 1'b0;
   logic        rst;
   logic        wr_en;
   logic [3:0]  wr_sel;
   logic [63:0] wr_data;
   logic        req_valid, req_base_on, req_idx_on;
   logic [3:0]  req_base_sel, req_idx_sel;
   logic [1:0]  req_scale, req_disp_w, req_size;
   logic [31:0] req_disp;
   logic        ea_valid;
   logic [63:0] ea_addr;
   logic [3:0]  ea_bytes;

   always #10 clk = ~clk;

   ea_scaled_agen u0 (.*);

   int          total = 0;
   int          bad = 0;
   bit          done = 0;
   string       cur_tag = "R2";
   logic [63:0] model [16];
   logic        exp_valid = 1'b0;
   logic [63:0] exp_addr = '0;
   logic [3:0]  exp_bytes = '0;

   function automatic logic [63:0] ref_ea(input logic bu, input logic [3:0] bs,
                                          input logic iu, input logic [3:0] is,
                                          input logic [1:0] sh, input logic [1:0] dc,
                                          input logic [31:0] dv);
      logic [63:0] s;
      s = 64'd0;
      if (bu) s = s + model[bs];
      if (iu && is != 4'd4) s = s + model[is] * (64'd1 << sh);
      case (dc)
         2'd1: s = s + 64'($signed(dv[7:0]));
         2'd2: s = s + 64'($signed(dv[15:0]));
         2'd3: s = s + 64'($signed(dv[31:0]));
         default: ;
      endcase
      return s;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   // drive one cycle of inputs and update the reference for the next edge
   task automatic drive(input logic we, input logic [3:0] ws, input logic [63:0] wd,
                        input logic rv, input logic bu, input logic [3:0] bs,
                        input logic iu, input logic [3:0] is, input logic [1:0] sh,
                        input logic [1:0] dc, input logic [31:0] dv, input logic [1:0] sz);
      wr_en = we; wr_sel = ws; wr_data = wd;
      req_valid = rv; req_base_on = bu; req_base_sel = bs;
      req_idx_on = iu; req_idx_sel = is; req_scale = sh;
      req_disp_w = dc; req_disp = dv; req_size = sz;
      exp_valid = rv;
      if (rv) begin
         exp_addr  = ref_ea(bu, bs, iu, is, sh, dc, dv);
         exp_bytes = 4'd1 << sz;
      end
      if (we) model[ws] = wd;
   endtask

   task automatic idle();
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic tick();
      @(negedge clk);
      chk({cur_tag, " valid"}, 64'(ea_valid), 64'(exp_valid));
      chk({cur_tag, " addr"},  ea_addr, exp_addr);
      chk({cur_tag, " bytes"}, 64'(ea_bytes), 64'(exp_bytes));
   endtask

   initial begin
      #(60000 * 20);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) model[i] = 64'd0;
      rst = 1'b1;
      idle();
      exp_valid = 0; exp_addr = 0; exp_bytes = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R2 reset state
      cur_tag = "R2"; idle(); tick();

      // load registers, no requests: outputs hold (R9)
      cur_tag = "R9";
      for (int i = 0; i < 16; i++) begin
         drive(1, 4'(i), 64'h1000 * (i + 1), 0, 0, 0, 0, 0, 0, 0, 0, 0); tick();
      end
      drive(1, 4'd2, 64'hF000, 0, 0, 0, 0, 0, 0, 0, 0, 0); tick();
      drive(1, 4'd1, 64'h0100, 0, 0, 0, 0, 0, 0, 0, 0, 0); tick();
      drive(1, 4'd3, 64'hF000, 0, 0, 0, 0, 0, 0, 0, 0, 0); tick();

      // R1 R3: base 0xF000 + 4*0x100
      cur_tag = "R1";
      drive(0, 0, 0, 1, 1, 4'd2, 1, 4'd1, 2'd2, 2'd0, 0, 2'd3); tick();
      chk("R1 example a", ea_addr, 64'hF400);
      chk("R7 qword", 64'(ea_bytes), 64'd8);
      // no base, index 0xF000 * 2 + 0x80 (16-bit disp)
      cur_tag = "R5";
      drive(0, 0, 0, 1, 0, 4'd9, 1, 4'd3, 2'd1, 2'd2, 32'hABCD_0080, 2'd0); tick();
      chk("R5 example b", ea_addr, 64'h1E080);
      chk("R7 byte", 64'(ea_bytes), 64'd1);
      // hold through idle (R9)
      cur_tag = "R9"; idle(); tick();
      chk("R9 hold", ea_addr, 64'h1E080);

      // R3 each scale
      cur_tag = "R3";
      for (int s = 0; s < 4; s++) begin
         drive(0, 0, 0, 1, 0, 0, 1, 4'd1, 2'(s), 0, 0, 2'(s)); tick();
         chk("R3 scale", ea_addr, 64'h100 << s);
         chk("R7 size", 64'(ea_bytes), 64'd1 << s);
      end

      // R6: index number 4 ignored; index off ignored
      cur_tag = "R6";
      drive(0, 0, 0, 1, 1, 4'd2, 1, 4'd4, 2'd3, 0, 0, 2'd1); tick();
      chk("R6 sp index", ea_addr, 64'hF000);
      drive(0, 0, 0, 1, 1, 4'd2, 0, 4'd1, 2'd3, 0, 0, 2'd1); tick();
      chk("R6 index off", ea_addr, 64'hF000);

      // R4: 8-bit negative disp with junk upper bits
      cur_tag = "R4";
      drive(0, 0, 0, 1, 1, 4'd2, 0, 0, 0, 2'd1, 32'h5A5A_5A80, 2'd2); tick();
      chk("R4 disp8 neg", ea_addr, 64'hF000 - 64'd128);
      drive(0, 0, 0, 1, 1, 4'd2, 0, 0, 0, 2'd0, 32'hFFFF_FFFF, 2'd2); tick();
      chk("R4 disp none", ea_addr, 64'hF000);
      drive(0, 0, 0, 1, 0, 0, 0, 0, 0, 2'd3, 32'h8000_0000, 2'd2); tick();
      chk("R4 disp32 neg", ea_addr, 64'hFFFF_FFFF_8000_0000);

      // R10 wrap
      cur_tag = "R10";
      drive(1, 4'd7, 64'hFFFF_FFFF_FFFF_FFF0, 0, 0, 0, 0, 0, 0, 0, 0, 0); tick();
      drive(0, 0, 0, 1, 1, 4'd7, 0, 0, 0, 2'd1, 32'h20, 2'd3); tick();
      chk("R10 wrap", ea_addr, 64'h10);
      drive(0, 0, 0, 1, 1, 4'd1, 0, 0, 0, 2'd1, 32'hFF, 2'd3); tick();
      chk("R10 neg disp", ea_addr, 64'hFF);

      // R8 same-cycle write and read returns old value
      cur_tag = "R8";
      drive(1, 4'd5, 64'h0000_0000_0000_0777, 1, 1, 4'd5, 1, 4'd5, 2'd0, 0, 0, 2'd3); tick();
      chk("R8 old value", ea_addr, 64'h6000 + 64'h6000);
      drive(0, 0, 0, 1, 1, 4'd5, 0, 0, 0, 0, 0, 2'd3); tick();
      chk("R8 new value", ea_addr, 64'h777);

      // mixed traffic against the reference on every clock (R1)
      cur_tag = "R1";
      for (int n = 0; n < 400; n++) begin
         drive(1'($urandom), 4'($urandom), {$urandom, $urandom},
               1'($urandom), 1'($urandom), 4'($urandom), 1'($urandom), 4'($urandom),
               2'($urandom), 2'($urandom), $urandom, 2'($urandom));
         tick();
      end

      // R2 reset mid-run clears outputs
      cur_tag = "R2";
      drive(0, 0, 0, 1, 1, 4'd2, 0, 0, 0, 0, 0, 2'd3);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      exp_valid = 0; exp_addr = 0; exp_bytes = 0;
      for (int i = 0; i < 16; i++) model[i] = 64'd0;
      idle(); tick();

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule